// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses the direction of conditional branches from a small table of 2-bit saturating counters. A fetch stage presents a program counter on the lookup port and gets back, in the same cycle, a predicted-taken bit. The execute stage reports each resolved branch on the update port: its program counter, its real outcome and a valid strobe.

The counter for that branch then moves one step toward the outcome. One cycle after the update, the block reports whether the guess was wrong and how many stall cycles the wrong guess costs. It also raises a jump marker when the branch was taken. The marker tells the instruction after the branch that it follows a redirect, which the fetch logic uses for its line-alignment penalty.

Instructions are halfword aligned, so the lowest PC bit carries no information. The table is indexed by the PC taken modulo `NSPAN` and then shifted right by one, which gives `NSPAN/2` counters.

Top module: `bpred_table`

## Requirements
- R1: After reset every counter holds 0, so a lookup at any PC returns not-taken.
- R2: The table entry used is (PC mod NSPAN) >> 1, i.e. PC bits [log2(NSPAN)-1:1]. PC bit 0 and all bits at or above log2(NSPAN) do not change which entry is used.
- R3: `lk_taken` equals bit 1 of the addressed counter, so counter values 2 and 3 predict taken and 0 and 1 predict not-taken.
- R4: An update with `up_valid`=1 and `up_taken`=1 increments the addressed counter, which saturates at 3.
- R5: An update with `up_valid`=1 and `up_taken`=0 decrements the addressed counter, which saturates at 0.
- R6: One cycle after a valid update, `up_mispredict` is 1 exactly when `up_taken` differed from bit 1 of the counter value held before that update. `up_stall` is then PENALTY (default 2); otherwise it is 0.
- R7: One cycle after a valid update with `up_taken`=1, `jump_mark` is 1. After a valid not-taken update it is 0.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the prediction from the counter value before the update.
- R9: When `up_valid`=0, no counter changes, and in the next cycle `up_mispredict`, `up_stall` and `jump_mark` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | PC to predict |
| lk_taken | output | 1 | Predicted taken, combinational from `lk_pc` |
| up_valid | input | 1 | Resolved branch present this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Real outcome of the resolved branch |
| up_mispredict | output | 1 | Previous cycle's update was mispredicted |
| up_stall | output | STALL_W | Stall cycles charged for that update |
| jump_mark | output | 1 | Previous cycle's update was a taken branch |

## Verification
The lookup result depends only on `lk_pc` and the table, so the bench samples it 1 ns after driving the inputs, in the same low clock phase and before the edge that writes the update. That sample is how R8 is observed. `up_mispredict`, `up_stall` and `jump_mark` pass through one register, so the bench holds the values it expects for an update and compares them at the next falling edge. Counter moves made by an update are seen through later lookups at the same entry.

// File: rtl/bpred_table.sv
module bpred_table #(
  parameter int NSPAN   = 16,
  parameter int PC_W    = 32,
  parameter int PENALTY = 2,
  parameter int STALL_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    lk_pc,
  output logic               lk_taken,
  input  logic               up_valid,
  input  logic [PC_W-1:0]    up_pc,
  input  logic               up_taken,
  output logic               up_mispredict,
  output logic [STALL_W-1:0] up_stall,
  output logic               jump_mark
);
  localparam int IW  = $clog2(NSPAN) - 1;
  localparam int ENT = NSPAN / 2;

  logic [1:0]    ctr [ENT];
  logic [IW-1:0] lk_idx, up_idx;
  logic [1:0]    cur;
  logic          miss_q, jump_q;

  assign lk_idx   = lk_pc[IW:1];
  assign up_idx   = up_pc[IW:1];
  assign lk_taken = ctr[lk_idx][1];
  assign cur      = ctr[up_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) ctr[i] <= 2'd0;
      miss_q <= 1'b0;
      jump_q <= 1'b0;
    end else begin
      miss_q <= up_valid && (up_taken != cur[1]);
      jump_q <= up_valid && up_taken;
      if (up_valid) begin
        if (up_taken && cur != 2'd3)       ctr[up_idx] <= cur + 2'd1;
        else if (!up_taken && cur != 2'd0) ctr[up_idx] <= cur - 2'd1;
      end
    end
  end

  assign up_mispredict = miss_q;
  assign up_stall      = miss_q ? STALL_W'(PENALTY) : '0;
  assign jump_mark     = jump_q;
endmodule

module bpred_table_chk #(
  parameter int NSPAN   = 16,
  parameter int PC_W    = 32,
  parameter int PENALTY = 2,
  parameter int STALL_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PC_W-1:0]    lk_pc,
  input logic               lk_taken,
  input logic               up_valid,
  input logic [PC_W-1:0]    up_pc,
  input logic               up_taken,
  input logic               up_mispredict,
  input logic [STALL_W-1:0] up_stall,
  input logic               jump_mark
);
  localparam int IW = $clog2(NSPAN) - 1;
  logic same;
  assign same = lk_pc[IW:1] == up_pc[IW:1];

  p_taken_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && same && lk_taken) |=> (lk_taken || lk_pc[IW:1] != $past(lk_pc[IW:1])));
  p_nottaken_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && same && !lk_taken) |=> (!lk_taken || lk_pc[IW:1] != $past(lk_pc[IW:1])));
  p_miss_needs_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_mispredict |-> (up_stall == STALL_W'(PENALTY)));
  p_jump_after_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken) |=> jump_mark);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> (!up_mispredict && !jump_mark && up_stall == '0));
endmodule

bind bpred_table bpred_table_chk #(.NSPAN(NSPAN), .PC_W(PC_W), .PENALTY(PENALTY), .STALL_W(STALL_W)) u_chk (.*);

// File: tb/bpred_table_test.sv
module bpred_table_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSPAN = 16;
  localparam int ENT = NSPAN / 2;

  logic clk = 0, rst_n = 0;
  logic [31:0] lk_pc = 0, up_pc = 0;
  logic up_valid = 0, up_taken = 0;
  logic lk_taken, up_mispredict, jump_mark;
  logic [1:0] up_stall;

  int checks = 0, bad = 0;
  int mdl [ENT];
  logic e_miss = 0, e_jump = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpred_table uut (.clk, .rst_n, .lk_pc, .lk_taken, .up_valid, .up_pc, .up_taken,
                   .up_mispredict, .up_stall, .jump_mark);

  function automatic int idx_of(input logic [31:0] pc);
    return (pc % NSPAN) / 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] lpc, input logic uv, input logic [31:0] upc, input logic ut);
    int k;
    @(negedge clk);
    chk("R6 mispredict", up_mispredict, e_miss);
    chk("R6 stall", up_stall, e_miss ? 2 : 0);
    chk(uv ? "R7 jump" : "R7/R9 jump", jump_mark, e_jump);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
    #1;
    chk("R3/R8 lookup", lk_taken, mdl[idx_of(lpc)] >= 2);
    k = idx_of(upc);
    e_miss = uv && (ut != (mdl[k] >= 2));
    e_jump = uv && ut;
    if (uv) begin
      if (ut && mdl[k] < 3) mdl[k]++;
      else if (!ut && mdl[k] > 0) mdl[k]--;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    for (int i = 0; i < ENT; i++) mdl[i] = 0;
    #(CLK_PERIOD * 2 + 1);
    // R1: reset state at every entry
    for (int i = 0; i < ENT; i++) begin
      lk_pc = i * 2; #1;
      chk("R1 reset", lk_taken, 0);
    end
    rst_n = 1;
    // R4: saturating increment at entry 3, R2 aliasing pc 6/7/0x16
    for (int i = 0; i < 5; i++) step(32'h6, 1, 32'h7 + i * 16, 1);
    step(32'h16, 0, 0, 0);
    chk("R2/R4 alias saturate", lk_taken, 1);
    // R5: saturating decrement, R8 same-cycle old value
    for (int i = 0; i < 5; i++) step(32'h6, 1, 32'h6, 0);
    step(32'h6, 0, 0, 0);
    chk("R5 saturate at 0", lk_taken, 0);
    // R9: idle cycles change nothing
    step(32'h2, 0, 32'h2, 1);
    step(32'h2, 0, 32'h2, 1);
    chk("R9 no change", lk_taken, 0);
    // R2: distinct neighbour entries
    step(32'h4, 1, 32'h2, 1);
    step(32'h2, 1, 32'h2, 1);
    step(32'h4, 0, 0, 0);
    chk("R2 neighbour untouched", lk_taken, 0);
    // random mix
    for (int n = 0; n < 3000; n++)
      step($urandom, ($urandom % 4) != 0, $urandom, $urandom % 2);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule